// File: doc/BRIEF.md
# Sound Generator Register Write Decoder

This block sits between a host byte bus and a four-voice sound generator. The generator has three tone voices and one noise voice. The host sends single bytes. A byte with its top bit set picks one of eight internal registers and loads that register's low nibble. The block remembers which register was picked. A byte with its top bit clear then goes to that remembered register. For a tone period, such a byte supplies the upper six bits of the ten-bit period. For anything else, it supplies the low nibble again. This lets a ten-bit period be loaded in two bytes, and it lets a volume be changed again with one short byte.

Parameters select between variants of the protocol:
- how a stored period of zero is presented (as 0x400 or as 0);
- whether short data bytes aimed at attenuation or noise-control registers are dropped;
- which register is selected after reset;
- the divide ratio of the internal tick.

A READY output falls after every write and recovers on the next divided tick. A one-cycle pulse tells the noise voice that its control field was rewritten.

Top module: `psg_reg_if`

## Requirements
- R1: A write whose bit 7 is 1 selects register number bits 6:4 and loads bits 3:0 into that register's low nibble. Register numbers are: 0, 2, 4 = tone periods 0..2; 6 = noise control; 1, 3, 5 = tone attenuations 0..2; 7 = noise attenuation. The selected number is remembered. Noise control takes only bits 2:0.
- R2: A write whose bit 7 is 0, while a tone-period register is remembered, loads bits 5:0 into period bits 9:4 and leaves period bits 3:0 unchanged.
- R3: A bit-7-clear write aimed at an attenuation register, or at noise control, replaces that register's low nibble (noise control: bits 2:0) with the data bits. Attenuations change only on writes.
- R4: With ZERO_IS_MAX=1, a stored tone period of zero appears on `tone_period` as 0x400. With ZERO_IS_MAX=0 it appears as 0. Non-zero periods appear unchanged.
- R5: With DROP_SHORT=1, a bit-7-clear write is ignored when the remembered register is odd or is 6. It then changes no output and produces no noise pulse.
- R6: After reset, all attenuations are 0, all periods and the noise control are 0, `ready` is 1, and the remembered register is PTR_AT_RESET.
- R7: `ready` is 0 in the cycle after any write. It returns to 1 in the cycle after the first divided tick that comes with no write in the same cycle.
- R8: The divided tick is present in every cycle when CLK_DIV=1. Otherwise it is present once every CLK_DIV cycles, first in the cycle after CLK_DIV-1 clock edges have passed since reset release.
- R9: `noise_ctl_wr` is 1 for exactly the cycle after each accepted write to register 6, and is 0 otherwise.
- R10: Every output reflects a write in the cycle right after the clock edge that sampled `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, sampled at each rising edge |
| wr_data | input | 8 | Write byte |
| tone_period | output | 3*(PER_W+1) | Effective tone periods, voice 0 in the low bits |
| tone_atten | output | 3*ATT_W | Tone attenuations, voice 0 in the low bits |
| noise_atten | output | ATT_W | Noise attenuation |
| noise_ctl | output | NCTL_W | Noise control field |
| noise_ctl_wr | output | 1 | One-cycle pulse after a noise-control write |
| ready | output | 1 | Low while a write is being absorbed |

## Verification
A wrong remembered register shows up on the first bit-7-clear byte after it. The nibble then lands in the wrong register, and the mismatch appears one cycle later on a period or attenuation port. A nibble-merge error shows as a period that is wrong in only its upper or only its lower bits. A divider phase error shows as `ready` recovering one or more cycles early or late after a write. In the dropping variant, a wrong acceptance rule shows as a changed attenuation or a stray noise pulse after a byte that should have been ignored.

// File: rtl/psg_wr_pkg.sv
package psg_wr_pkg;
  localparam int NTONE = 3;
  localparam int NVOL  = 4;
  typedef logic [2:0] reg_sel_t;
  localparam reg_sel_t NOISE_CTL_SEL = 3'd6;
endpackage

// File: rtl/psg_tick_gen.sv
module psg_tick_gen #(
  parameter int CLK_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (CLK_DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(CLK_DIV);
      localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == LAST);
      assert_cnt_range_R8: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
      assert_tick_gap_R8: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/psg_ready_ctl.sv
module psg_ready_ctl (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic tick,
  output logic ready
);
  always_ff @(posedge clk) begin
    if (rst) ready <= 1'b1;
    else if (wr_en) ready <= 1'b0;
    else if (tick) ready <= 1'b1;
  end

  assert_ready_drop_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !ready);
  assert_ready_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> ($past(tick) && !$past(wr_en)));
  assert_ready_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (ready && !wr_en) |=> ready);
endmodule

// File: rtl/psg_reg_decode.sv
module psg_reg_decode
  import psg_wr_pkg::*;
#(
  parameter int PER_W        = 10,
  parameter int ATT_W        = 4,
  parameter int NCTL_W       = 3,
  parameter bit ZERO_IS_MAX  = 1'b1,
  parameter bit DROP_SHORT   = 1'b0,
  parameter int PTR_AT_RESET = 0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [7:0]                  wr_data,
  output logic [NTONE*(PER_W+1)-1:0]  per_eff,
  output logic [NVOL*ATT_W-1:0]       att_flat,
  output logic [NCTL_W-1:0]           nctl,
  output logic                        nctl_wr
);
  localparam int HI_W = PER_W - 4;
  localparam logic [PER_W:0] ZERO_VAL = ZERO_IS_MAX ? {1'b1, {PER_W{1'b0}}} : '0;

  reg_sel_t ptr_q;
  logic [NTONE-1:0][PER_W-1:0] per_q, per_n;
  logic [NVOL-1:0][ATT_W-1:0]  att_q, att_n;
  logic [NCTL_W-1:0]           nctl_n;
  logic                        is_latch, accept, hits_ctl;
  reg_sel_t                    tgt;

  always_comb begin
    is_latch = wr_data[7];
    tgt      = is_latch ? reg_sel_t'(wr_data[6:4]) : ptr_q;
    accept   = wr_en && (is_latch || !(DROP_SHORT && (tgt[0] || tgt == NOISE_CTL_SEL)));
    hits_ctl = accept && (tgt == NOISE_CTL_SEL);
    per_n    = per_q;
    att_n    = att_q;
    nctl_n   = nctl;
    if (accept) begin
      if (tgt[0]) begin
        att_n[tgt[2:1]] = wr_data[ATT_W-1:0];
      end else if (tgt == NOISE_CTL_SEL) begin
        nctl_n = wr_data[NCTL_W-1:0];
      end else if (is_latch) begin
        per_n[tgt[2:1]][3:0] = wr_data[3:0];
      end else begin
        per_n[tgt[2:1]][PER_W-1:4] = wr_data[HI_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= reg_sel_t'(PTR_AT_RESET);
      per_q   <= '0;
      att_q   <= '0;
      nctl    <= '0;
      nctl_wr <= 1'b0;
    end else begin
      if (wr_en && is_latch) ptr_q <= reg_sel_t'(wr_data[6:4]);
      per_q   <= per_n;
      att_q   <= att_n;
      nctl    <= nctl_n;
      nctl_wr <= hits_ctl;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NTONE; gi++) begin : g_eff
      always_ff @(posedge clk) begin
        if (rst) per_eff[gi*(PER_W+1) +: PER_W+1] <= ZERO_VAL;
        else if (per_n[gi] == '0) per_eff[gi*(PER_W+1) +: PER_W+1] <= ZERO_VAL;
        else per_eff[gi*(PER_W+1) +: PER_W+1] <= {1'b0, per_n[gi]};
      end
    end
  endgenerate

  assign att_flat = att_q;

  assert_ptr_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[7]) |=> $stable(ptr_q));
  assert_att_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(att_q));
  assert_per_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(per_q));
  assert_nwr_cause_R9: assert property (@(posedge clk) disable iff (rst)
    nctl_wr |-> $past(wr_en));

  generate
    if (DROP_SHORT) begin : g_drop_chk
      assert_drop_att_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[7] && (ptr_q[0] || ptr_q == NOISE_CTL_SEL)) |=>
          ($stable(att_q) && $stable(nctl) && !nctl_wr));
    end
  endgenerate
endmodule

// File: rtl/psg_reg_if.sv
module psg_reg_if
  import psg_wr_pkg::*;
#(
  parameter int PER_W        = 10,
  parameter int ATT_W        = 4,
  parameter int NCTL_W       = 3,
  parameter int CLK_DIV      = 8,
  parameter bit ZERO_IS_MAX  = 1'b1,
  parameter bit DROP_SHORT   = 1'b0,
  parameter int PTR_AT_RESET = 0
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [7:0]                     wr_data,
  output logic [3*(PER_W+1)-1:0]         tone_period,
  output logic [3*ATT_W-1:0]             tone_atten,
  output logic [ATT_W-1:0]               noise_atten,
  output logic [NCTL_W-1:0]              noise_ctl,
  output logic                           noise_ctl_wr,
  output logic                           ready
);
  logic                     tick;
  logic [NVOL*ATT_W-1:0]    att_flat;

  psg_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  psg_reg_decode #(
    .PER_W(PER_W), .ATT_W(ATT_W), .NCTL_W(NCTL_W),
    .ZERO_IS_MAX(ZERO_IS_MAX), .DROP_SHORT(DROP_SHORT), .PTR_AT_RESET(PTR_AT_RESET)
  ) u_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .per_eff(tone_period), .att_flat(att_flat),
    .nctl(noise_ctl), .nctl_wr(noise_ctl_wr)
  );

  psg_ready_ctl u_rdy (
    .clk(clk), .rst(rst), .wr_en(wr_en), .tick(tick), .ready(ready)
  );

  assign tone_atten  = att_flat[3*ATT_W-1:0];
  assign noise_atten = att_flat[NVOL*ATT_W-1 -: ATT_W];
endmodule

// File: tb/sim_psg_reg_if.sv
module sim_psg_reg_if;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  logic [32:0] tp0, tp1;
  logic [11:0] ta0, ta1;
  logic [3:0]  na0, na1;
  logic [2:0]  nc0, nc1;
  logic        nw0, nw1, rd0, rd1;

  psg_reg_if u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .tone_period(tp0), .tone_atten(ta0), .noise_atten(na0), .noise_ctl(nc0),
    .noise_ctl_wr(nw0), .ready(rd0));

  psg_reg_if #(.CLK_DIV(1), .ZERO_IS_MAX(1'b0), .DROP_SHORT(1'b1), .PTR_AT_RESET(3)) u1 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .tone_period(tp1), .tone_atten(ta1), .noise_atten(na1), .noise_ctl(nc1),
    .noise_ctl_wr(nw1), .ready(rd1));

  typedef struct {
    logic [2:0] ptr;
    logic [9:0] per [3];
    logic [3:0] att [4];
    logic [2:0] nctl;
    bit nwr;
    bit rdy;
    int cnt;
  } mdl_t;

  mdl_t m0, m1;

  function automatic mdl_t mreset(int p);
    mdl_t s;
    s.ptr = 3'(p);
    for (int i = 0; i < 3; i++) s.per[i] = '0;
    for (int i = 0; i < 4; i++) s.att[i] = '0;
    s.nctl = '0; s.nwr = 0; s.rdy = 1; s.cnt = 0;
    return s;
  endfunction

  function automatic mdl_t mstep(mdl_t s, bit drop, int div, bit we, logic [7:0] d);
    mdl_t n = s;
    logic [2:0] tgt;
    bit acc;
    n.nwr = 0;
    if (we) begin
      tgt = d[7] ? d[6:4] : s.ptr;
      acc = d[7] || !(drop && (tgt[0] || tgt == 3'd6));
      if (d[7]) n.ptr = d[6:4];
      if (acc) begin
        if (tgt[0]) n.att[tgt[2:1]] = d[3:0];
        else if (tgt == 3'd6) begin n.nctl = d[2:0]; n.nwr = 1; end
        else if (d[7]) n.per[tgt[2:1]][3:0] = d[3:0];
        else n.per[tgt[2:1]][9:4] = d[5:0];
      end
      n.rdy = 0;
    end else if (div <= 1 || s.cnt == div - 1) n.rdy = 1;
    n.cnt = (div <= 1 || s.cnt == div - 1) ? 0 : s.cnt + 1;
    return n;
  endfunction

  function automatic int eff(logic [9:0] p, bit zmax);
    return (p == 0) ? (zmax ? 'h400 : 0) : int'(p);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m0 <= mreset(0);
      m1 <= mreset(3);
    end else begin
      m0 <= mstep(m0, 1'b0, 8, wr_en, wr_data);
      m1 <= mstep(m1, 1'b1, 1, wr_en, wr_data);
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    for (int i = 0; i < 3; i++) begin
      chk("R2 u0 period", int'(tp0[i*11 +: 11]), eff(m0.per[i], 1'b1));
      chk("R4 u1 period", int'(tp1[i*11 +: 11]), eff(m1.per[i], 1'b0));
      chk("R3 u0 atten", int'(ta0[i*4 +: 4]), int'(m0.att[i]));
      chk("R5 u1 atten", int'(ta1[i*4 +: 4]), int'(m1.att[i]));
    end
    chk("R3 u0 noise atten", int'(na0), int'(m0.att[3]));
    chk("R5 u1 noise atten", int'(na1), int'(m1.att[3]));
    chk("R1 u0 noise ctl", int'(nc0), int'(m0.nctl));
    chk("R1 u1 noise ctl", int'(nc1), int'(m1.nctl));
    chk("R9 u0 pulse", int'(nw0), int'(m0.nwr));
    chk("R9 u1 pulse", int'(nw1), int'(m1.nwr));
    chk("R7 u0 ready", int'(rd0), int'(m0.rdy));
    chk("R7 u1 ready", int'(rd1), int'(m1.rdy));
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lowc;
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6: reset values
    chk("R6 u0 period0 reset (R4 max)", int'(tp0[10:0]), 'h400);
    chk("R6 u1 period0 reset", int'(tp1[10:0]), 0);
    chk("R6 u0 atten reset", int'(ta0), 0);
    chk("R6 ready reset", int'(rd0 & rd1), 1);
    // R6/R5: first data byte uses reset pointer (u0: reg 0, u1: reg 3 dropped)
    wr(8'h15);
    chk("R6 u0 ptr0 data", int'(tp0[10:0]), 'h150);
    chk("R5 u1 dropped", int'(ta1[7:4]), 0);
    chk("R10 u0 ready low", int'(rd0), 0);
    // R1 + R10 latch low nibble
    wr(8'h86);
    chk("R1 u0 latch low", int'(tp0[10:0]), 'h156);
    chk("R10 u1 latch", int'(tp1[10:0]), 'h006);
    // R9 noise control latch
    wr(8'hE5);
    chk("R9 u0 pulse", int'(nw0), 1);
    chk("R1 u1 nctl", int'(nc1), 5);
    @(negedge clk);
    chk("R9 pulse ends", int'(nw0 | nw1), 0);
    // R5 data byte to noise control: u0 accepts, u1 drops
    wr(8'h02);
    chk("R3 u0 nctl data", int'(nc0), 2);
    chk("R5 u1 nctl kept", int'(nc1), 5);
    chk("R5 u1 no pulse", int'(nw1), 0);
    // R4 zero period
    wr(8'hA0); wr(8'h00);
    chk("R4 u0 zero max", int'(tp0[21:11]), 'h400);
    chk("R4 u1 zero zero", int'(tp1[21:11]), 0);
    // R8: ready low span
    lowc = 0;
    wr(8'hB9);
    chk("R8 u1 ready after one", int'(rd1), 0);
    @(negedge clk);
    chk("R8 u1 ready back", int'(rd1), 1);
    lowc = 1;
    while (!rd0 && lowc < 20) begin @(negedge clk); lowc++; end
    chk("R8 u0 low span ok", int'(lowc >= 1 && lowc <= 8), 1);
    // random phase with per-cycle model compare
    for (int k = 0; k < 3000; k++) begin
      wr_en = ($urandom % 3) != 0;
      wr_data = 8'($urandom);
      @(negedge clk);
      cmp_all();
    end
    wr_en = 1'b0;
    repeat (10) begin @(negedge clk); cmp_all(); end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule